// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block sits beside the page loader of a nonvolatile byte array and inspects every captured host write. Two fixed address/data command strings are recognised. The short string arms protection. The long string removes it. Either string, once complete, also opens the current load so that the data bytes after it may be stored while protection is on. Bytes that belong to a command string are flagged so the loader drops them, and they never reach the array.

A protection change is held pending. It lands on the edge where the loader reports the end of its programming period. This happens even if the load carried no data at all. While protection is on, a load without a complete command prefix stores nothing. The loader still runs its timer, which is its own business.

The flag's reset value stands in for its retained value after power-up. Address comparison uses the 15 low address bits the block receives.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset, `protect_o` equals the parameter PROT_INIT (default 0), `load_unlocked_o` is 0, and `cmd_byte_o` and `store_ok_o` are 0 while `wr_stb` is low.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h in one load each raise `cmd_byte_o` with `store_ok_o` low in their strobe cycle. `protect_o` reads 1 on the cycle after the next `prog_done` pulse, even when no data byte follows.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h in one load are all flagged as command bytes. `protect_o` reads 0 on the cycle after the next `prog_done` pulse.
- R4: A command byte never has `store_ok_o` high. While unprotected, a write outside any sequence is stored, including writes to 5555h or 2AAAh with non-command data.
- R5: While protected, a write with no complete prefix earlier in the same load gives `store_ok_o` = 0 and `cmd_byte_o` = 0, and `protect_o` stays 1.
- R6: Once either command string completes in a load, every later byte of that load has `store_ok_o` = 1 and `cmd_byte_o` = 0, and `load_unlocked_o` is 1.
- R7: A write that does not match the next expected step of a partial string returns the matcher to idle. That write is judged as data, and a new string must begin again with its first byte.
- R8: A `load_close` pulse discards a partial, incomplete string, so the next byte is judged from idle.
- R9: On a `prog_done` pulse, any pending change is applied and `load_unlocked_o` falls on the following cycle. `protect_o` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | One-cycle pulse: a captured host write |
| wr_addr | input | 15 | Low address bits of the write |
| wr_data | input | 8 | Data byte of the write |
| load_close | input | 1 | Pulse: byte-load window expired, programming begins |
| prog_done | input | 1 | Pulse: programming period has ended |
| protect_o | output | 1 | Current write-protect state |
| load_unlocked_o | output | 1 | A full command string has been seen in the current load |
| cmd_byte_o | output | 1 | Current strobed byte is a command byte and must be dropped |
| store_ok_o | output | 1 | Current strobed byte may be written into the array |

## Verification
The properties assume that `wr_stb`, `load_close` and `prog_done` are one-cycle pulses that never coincide. They also assume that no write arrives between `load_close` and `prog_done`, so a load always ends with a close followed later by a done. The stimulus keeps to this order. It strobes bytes in separate cycles, closes each load, and waits idle cycles before pulsing done. Within a load, random bytes are mixed with the next expected command byte, so partial strings, breaks and complete strings all occur under both protect states.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;
  localparam int CMD_AW = 15;
  localparam int DW     = 8;

  localparam logic [CMD_AW-1:0] ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] ADDR_LO = 15'h2AAA;
  localparam logic [DW-1:0] D_LEAD  = 8'hAA;
  localparam logic [DW-1:0] D_PAIR  = 8'h55;
  localparam logic [DW-1:0] D_ARM   = 8'hA0;
  localparam logic [DW-1:0] D_ESC   = 8'h80;
  localparam logic [DW-1:0] D_DISARM = 8'h20;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_S1     = 3'd1,
    M_S2     = 3'd2,
    M_S3     = 3'd3,
    M_S4     = 3'd4,
    M_S5     = 3'd5,
    M_OPEN_EN  = 3'd6,
    M_OPEN_DIS = 3'd7
  } mstate_t;

  typedef struct packed {
    mstate_t nxt;
    logic    cmd;
    logic    en_hit;
    logic    dis_hit;
  } step_t;

  function automatic logic hit(input logic [CMD_AW-1:0] a, input logic [DW-1:0] d,
                               input logic [CMD_AW-1:0] ea, input logic [DW-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // One matcher step for a strobed byte. A mismatch from a partial string lands in idle.
  function automatic step_t seq_step(input mstate_t st, input logic [CMD_AW-1:0] a,
                                     input logic [DW-1:0] d);
    step_t r;
    r.nxt = M_IDLE;
    r.cmd = 1'b0;
    r.en_hit = 1'b0;
    r.dis_hit = 1'b0;
    case (st)
      M_IDLE: if (hit(a, d, ADDR_HI, D_LEAD)) begin r.nxt = M_S1; r.cmd = 1'b1; end
      M_S1:   if (hit(a, d, ADDR_LO, D_PAIR)) begin r.nxt = M_S2; r.cmd = 1'b1; end
      M_S2: begin
        if (hit(a, d, ADDR_HI, D_ARM)) begin
          r.nxt = M_OPEN_EN; r.cmd = 1'b1; r.en_hit = 1'b1;
        end else if (hit(a, d, ADDR_HI, D_ESC)) begin
          r.nxt = M_S3; r.cmd = 1'b1;
        end
      end
      M_S3:   if (hit(a, d, ADDR_HI, D_LEAD)) begin r.nxt = M_S4; r.cmd = 1'b1; end
      M_S4:   if (hit(a, d, ADDR_LO, D_PAIR)) begin r.nxt = M_S5; r.cmd = 1'b1; end
      M_S5: begin
        if (hit(a, d, ADDR_HI, D_DISARM)) begin
          r.nxt = M_OPEN_DIS; r.cmd = 1'b1; r.dis_hit = 1'b1;
        end
      end
      M_OPEN_EN:  r.nxt = M_OPEN_EN;
      M_OPEN_DIS: r.nxt = M_OPEN_DIS;
      default:    r.nxt = M_IDLE;
    endcase
    return r;
  endfunction

  function automatic logic is_open(input mstate_t st);
    return (st == M_OPEN_EN) || (st == M_OPEN_DIS);
  endfunction
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_close,
  input  logic              prog_done,
  output mstate_t           state_q,
  output logic              cmd_byte,
  output logic              en_hit,
  output logic              dis_hit,
  output logic              seq_open
);
  step_t step;

  always_comb begin
    step     = seq_step(state_q, wr_addr, wr_data);
    cmd_byte = wr_stb & step.cmd;
    en_hit   = wr_stb & step.en_hit;
    dis_hit  = wr_stb & step.dis_hit;
    seq_open = is_open(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= M_IDLE;
    else if (prog_done)
      state_q <= M_IDLE;
    else if (wr_stb)
      state_q <= step.nxt;
    else if (load_close && !seq_open)
      state_q <= M_IDLE;
  end
endmodule

// File: rtl/wp_state_reg.sv
module wp_state_reg #(
  parameter bit PROT_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_hit,
  input  logic dis_hit,
  input  logic prog_done,
  output logic protect_q,
  output logic pend_set,
  output logic pend_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
    end else if (prog_done) begin
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
    end else begin
      if (en_hit)  pend_set <= 1'b1;
      if (dis_hit) pend_clr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      protect_q <= PROT_INIT;
    else if (prog_done) begin
      if (pend_set)      protect_q <= 1'b1;
      else if (pend_clr) protect_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_store_gate.sv
module wp_store_gate (
  input  logic wr_stb,
  input  logic cmd_byte,
  input  logic protect,
  input  logic seq_open,
  output logic store_ok
);
  always_comb store_ok = wr_stb & ~cmd_byte & (~protect | seq_open);
endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wp_cmd_pkg::*;
#(
  parameter bit PROT_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_close,
  input  logic              prog_done,
  output logic              protect_o,
  output logic              load_unlocked_o,
  output logic              cmd_byte_o,
  output logic              store_ok_o
);
  mstate_t match_state;
  logic cmd_byte, en_hit, dis_hit, seq_open;
  logic pend_set, pend_clr, protect_q, store_ok;
  logic match_idle;

  wp_seq_match u_match (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_close(load_close), .prog_done(prog_done), .state_q(match_state),
    .cmd_byte(cmd_byte), .en_hit(en_hit), .dis_hit(dis_hit), .seq_open(seq_open)
  );

  wp_state_reg #(.PROT_INIT(PROT_INIT)) u_state (
    .clk(clk), .rst_n(rst_n), .en_hit(en_hit), .dis_hit(dis_hit), .prog_done(prog_done),
    .protect_q(protect_q), .pend_set(pend_set), .pend_clr(pend_clr)
  );

  wp_store_gate u_gate (
    .wr_stb(wr_stb), .cmd_byte(cmd_byte), .protect(protect_q), .seq_open(seq_open),
    .store_ok(store_ok)
  );

  assign match_idle      = (match_state == M_IDLE);
  assign protect_o       = protect_q;
  assign load_unlocked_o = seq_open;
  assign cmd_byte_o      = cmd_byte;
  assign store_ok_o      = store_ok;
endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic load_close,
  input logic prog_done,
  input logic protect_o,
  input logic load_unlocked_o,
  input logic cmd_byte_o,
  input logic store_ok_o,
  input logic en_hit,
  input logic dis_hit,
  input logic pend_set,
  input logic pend_clr,
  input logic match_idle
);
  a_r9_flag_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_o != $past(protect_o)) |-> $past(prog_done));

  a_r9_done_closes_load: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !load_unlocked_o);

  a_r2_arm_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hit && !prog_done) |=> pend_set);

  a_r3_disarm_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_hit && !prog_done) |=> pend_clr);

  a_r4_cmd_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte_o |-> (!store_ok_o && wr_stb));

  a_r5_locked_needs_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ok_o && protect_o) |-> load_unlocked_o);

  a_r8_close_drops_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (load_close && !load_unlocked_o && !wr_stb && !prog_done) |=> match_idle);
endmodule

bind wp_cmd_guard wp_cmd_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .load_close(load_close), .prog_done(prog_done),
  .protect_o(protect_o), .load_unlocked_o(load_unlocked_o), .cmd_byte_o(cmd_byte_o),
  .store_ok_o(store_ok_o), .en_hit(en_hit), .dis_hit(dis_hit), .pend_set(pend_set),
  .pend_clr(pend_clr), .match_idle(match_idle)
);

// File: tb/tb_wp_cmd_guard.sv
`timescale 1ns/1ps
module tb_wp_cmd_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic load_close = 1'b0;
  logic prog_done = 1'b0;
  logic protect_o, load_unlocked_o, cmd_byte_o, store_ok_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model: matched count, open flag, kind (1 arm, 2 disarm), protect
  int  bm = 0;
  bit  bopen = 0;
  int  bkind = 0;
  bit  mprot = 0;

  always #10 clk = ~clk;

  wp_cmd_guard dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_close(load_close), .prog_done(prog_done), .protect_o(protect_o),
    .load_unlocked_o(load_unlocked_o), .cmd_byte_o(cmd_byte_o), .store_ok_o(store_ok_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] want_a(input int m);
    return (m == 1 || m == 4) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] want_d(input int m, input int kind);
    case (m)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return (kind == 1) ? 8'hA0 : 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  task automatic model_wr(input logic [14:0] a, input logic [7:0] d, output bit c, output bit s);
    c = 0;
    if (!bopen) begin
      if (bm == 2 && a == 15'h5555 && d == 8'hA0) begin c = 1; bopen = 1; bkind = 1; end
      else if (bm == 2 && a == 15'h5555 && d == 8'h80) begin c = 1; bm = 3; end
      else if (bm != 2 && a == want_a(bm) && d == want_d(bm, 0)) begin
        c = 1; bm++;
        if (bm == 6) begin bopen = 1; bkind = 2; end
      end else bm = 0;
    end
    s = !c && (!mprot || bopen);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input string req);
    bit c, s;
    model_wr(a, d, c, s);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #2;
    chk({req, " cmd"}, cmd_byte_o, c);
    chk({req, " store"}, store_ok_o, s);
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic close_load(input string req);
    @(negedge clk);
    load_close = 1'b1;
    @(posedge clk); #1;
    load_close = 1'b0;
    if (!bopen) bm = 0;
    chk({req, " unlocked after close"}, load_unlocked_o, bopen);
    chk({req, " flag held before done"}, protect_o, mprot);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_prog(input string req);
    @(negedge clk);
    prog_done = 1'b1;
    @(posedge clk); #1;
    prog_done = 1'b0;
    if (bopen) mprot = (bkind == 1);
    bopen = 0; bm = 0; bkind = 0;
    chk({req, " flag after done"}, protect_o, mprot);
    chk({req, " unlocked cleared"}, load_unlocked_o, 1'b0);
  endtask

  task automatic seq_arm();
    wr(15'h5555, 8'hAA, "R2"); wr(15'h2AAA, 8'h55, "R2"); wr(15'h5555, 8'hA0, "R2");
  endtask

  task automatic seq_disarm();
    wr(15'h5555, 8'hAA, "R3"); wr(15'h2AAA, 8'h55, "R3"); wr(15'h5555, 8'h80, "R3");
    wr(15'h5555, 8'hAA, "R3"); wr(15'h2AAA, 8'h55, "R3"); wr(15'h5555, 8'h20, "R3");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 protect reset", protect_o, 1'b0);
    chk("R1 unlocked reset", load_unlocked_o, 1'b0);
    chk("R1 cmd idle", cmd_byte_o, 1'b0);
    chk("R1 store idle", store_ok_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R4: plain writes to command addresses are data when unprotected
    wr(15'h5555, 8'h12, "R4"); wr(15'h2AAA, 8'h55, "R4"); wr(15'h0100, 8'hAA, "R4");
    close_load("R4"); finish_prog("R4");

    // R2: arm with no data following
    seq_arm(); close_load("R2");
    chk("R2 unlocked", load_unlocked_o, 1'b1);
    finish_prog("R2");
    chk("R2 armed", protect_o, 1'b1);

    // R5: protected write without prefix
    wr(15'h0042, 8'h77, "R5"); wr(15'h0043, 8'h78, "R5");
    close_load("R5"); finish_prog("R5");
    chk("R5 still armed", protect_o, 1'b1);

    // R6: prefix then data while protected
    seq_arm(); wr(15'h1234, 8'h9C, "R6"); wr(15'h5555, 8'hAA, "R6");
    chk("R6 unlocked", load_unlocked_o, 1'b1);
    close_load("R6"); finish_prog("R6");

    // R7: break partial string, then restart
    wr(15'h5555, 8'hAA, "R7"); wr(15'h0001, 8'h55, "R7"); wr(15'h2AAA, 8'h55, "R7");
    seq_arm(); wr(15'h0002, 8'h03, "R7");
    close_load("R7"); finish_prog("R7");

    // R8: close drops a partial string
    wr(15'h5555, 8'hAA, "R8"); wr(15'h2AAA, 8'h55, "R8");
    close_load("R8"); finish_prog("R8");
    wr(15'h5555, 8'hA0, "R8");
    chk("R8 not cmd", cmd_byte_o, 1'b0);
    close_load("R8"); finish_prog("R8");

    // R3: disarm with a data byte after it
    seq_disarm(); wr(15'h0200, 8'h44, "R3");
    close_load("R3"); finish_prog("R3");
    chk("R3 disarmed", protect_o, 1'b0);

    // random loads, R9 exercised at each done
    for (int ld = 0; ld < 300; ld++) begin
      int nb = 1 + ($urandom % 8);
      int kind = 1 + ($urandom % 2);
      for (int b = 0; b < nb; b++) begin
        logic [14:0] a; logic [7:0] d;
        if (!bopen && ($urandom % 100) < 70) begin
          a = want_a(bm); d = want_d(bm, kind);
        end else begin
          case ($urandom % 3)
            0: a = 15'h5555;
            1: a = 15'h2AAA;
            default: a = 15'($urandom);
          endcase
          d = ($urandom % 2) ? 8'($urandom) : want_d($urandom % 6, kind);
        end
        wr(a, d, "R9 rand");
      end
      close_load("R9 rand");
      finish_prog("R9 rand");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule